// File: doc/BRIEF.md
# Event Time Capture Counter

This block is a free-running up-counter that takes a snapshot of its own value whenever a store event occurs. Software starts the counter with a run bit. From then on it advances by one on every clock. An event copies the live count into an image register. Each event source is edge-triggered and can be masked on its own. There are three sources:
- an external pin;
- a strobe from neighbouring on-chip logic;
- a software store command.

A freeze handshake lets a bus master read the image without it changing under the read. Software raises a freeze request, and an acknowledge follows one clock later. While the acknowledge is high the image is held, and any snapshot that arrives is kept aside as pending. That pending value is written to the image once the freeze is lifted. The counter keeps running throughout. To measure a pulse width, feed two units with the signal and with its inverse, then subtract their images.

Top module: `evcap_timer`

## Requirements
- R1: Writing control (address 0) with bit 1 set zeroes the counter, the image and the pending flag at that clock edge. Bit 1 is a strobe and always reads back as 0.
- R2: After reset, control, image (address 2) and count (address 3) all read 0. The counter advances by exactly one per clock while control bit 0 (run) is 1, and holds its value while that bit is 0.
- R3: Writing address 1 with bit 0 set issues a software store. If that write is taken at edge k, then at edge k+1 the image receives the value the counter held just before edge k+1.
- R4: The pin and logic sources each pass through a two-stage synchroniser followed by a rising-edge detector. If an input is first sampled high at edge k, then at edge k+2 the image receives the value the counter held just before edge k+2.
- R5: Control bits 3, 4 and 5 enable the pin, logic and software sources respectively. An event from a source whose enable bit is 0 leaves the image unchanged.
- R6: Control bit 2 requests a freeze. The acknowledge, read back at control bit 6, equals the request one clock later. While the acknowledge is 1, the image holds its value and the counter keeps counting.
- R7: Rising edges on one source that are sampled two clocks apart are both captured, so the image ends at the value from the later edge.
- R8: A store event that arrives while the acknowledge is 1 sets the pending flag (control bit 7). Only the newest such value is kept. It is written to the image one clock after the acknowledge falls, and the pending flag then clears.
- R9: The counter is 16 bits wide and wraps from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_evt_i | input | 1 | Store event from an external pin (asynchronous) |
| logic_evt_i | input | 1 | Store event from neighbouring logic (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 software store, 2 image, 3 count |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Read data for the register at bus_addr_i |

## Verification
Software, pin and logic stores are each issued at a known count. Their images differ by exactly the one-clock or two-clock latency, which separates the direct path from the synchronised path. Two units are driven by a pulse and by its inverse, with widths of 7 and 2 clocks. The difference of their images must equal the width, which catches an off-by-one in either edge path. A 1-0-1 pattern on one pin must end at the later snapshot. Masked pulses must leave the image untouched. During a freeze, two stores must leave the image frozen and then release only the newer value.

// File: rtl/evcap_pkg.sv
// Package evcap_pkg: register addresses and control-bit positions shared
// by the capture counter and its bench. Assumes a 2-bit register address.
package evcap_pkg;
    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_SWSTORE = 2'd1,
        REG_IMAGE   = 2'd2,
        REG_COUNT   = 2'd3
    } reg_addr_e;

    localparam int CB_RUN     = 0;
    localparam int CB_CLEAR   = 1;
    localparam int CB_FREEZE  = 2;
    localparam int CB_EN_PIN  = 3;
    localparam int CB_EN_LOG  = 4;
    localparam int CB_EN_SW   = 5;
    localparam int CB_ACK     = 6;
    localparam int CB_PENDING = 7;
    localparam int CTRL_W     = 8;
    localparam int NUM_EXT    = 2;
endpackage

// File: rtl/evcap_edge.sv
// Module evcap_edge: brings an asynchronous event line into the clock
// domain through a synchroniser chain and emits a one-cycle pulse on each
// rising edge. Assumes STAGES >= 1 and that the line holds each level for
// at least one clock.
module evcap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single-stage capture of the input line.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= async_i;
            end
        end else begin : g_chain
            // Purpose: shift the input line through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[MSB-1:0], async_i};
            end
        end
    endgenerate

    // Purpose: remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[MSB];
    end

    assign rise_o = sync_q[MSB] & ~prev_q;
endmodule

// File: rtl/evcap_core.sv
// Module evcap_core: the running counter, the image register, the freeze
// acknowledge and the pending snapshot. Assumes clr_i, cap_i and the
// freeze request are already synchronous single-clock signals.
module evcap_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             cap_i,
    input  logic             frz_req_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] img_o,
    output logic             ack_o,
    output logic             pend_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] img_q;
    logic [CNT_W-1:0] pval_q;
    logic             ack_q;
    logic             pend_q;

    // Purpose: free-running counter, cleared by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (run_i)      cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: acknowledge tracks the freeze request one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= frz_req_i;
    end

    // Purpose: snapshot into image, or into the pending slot when frozen.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            img_q  <= '0;
            pval_q <= '0;
            pend_q <= 1'b0;
        end else if (cap_i) begin
            if (ack_q) begin
                pval_q <= cnt_q;
                pend_q <= 1'b1;
            end else begin
                img_q  <= cnt_q;
                pend_q <= 1'b0;
            end
        end else if (pend_q && !ack_q) begin
            img_q  <= pval_q;
            pend_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign img_o  = img_q;
    assign ack_o  = ack_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/evcap_timer.sv
// Module evcap_timer: top level of the capture counter. It holds the
// control register, decodes bus writes into strobes, synchronises the two
// external event lines and muxes read data. Assumes CNT_W >= 8 so that the
// control byte fits in a read word.
module evcap_timer
    import evcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_evt_i,
    input  logic             logic_evt_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    output logic [CNT_W-1:0] bus_rdata_o
);
    localparam int NSRC = NUM_EXT + 1;

    logic             run_q;
    logic             frz_req_q;
    logic [NSRC-1:0]  en_q;
    logic             sw_stb_q;
    logic             clr_stb;
    logic             wr_ctrl;
    logic             wr_sw;
    logic [NUM_EXT-1:0] ext_raw;
    logic [NUM_EXT-1:0] ext_rise;
    logic             cap_any;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] img_q;
    logic             ack_q;
    logic             pend_q;

    assign wr_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);
    assign wr_sw   = bus_wr_i && (bus_addr_i == REG_SWSTORE);
    assign clr_stb = wr_ctrl && bus_wdata_i[CB_CLEAR];

    // Purpose: control register holding run, freeze request and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            frz_req_q <= 1'b0;
            en_q      <= '0;
        end else if (wr_ctrl) begin
            run_q     <= bus_wdata_i[CB_RUN];
            frz_req_q <= bus_wdata_i[CB_FREEZE];
            en_q      <= bus_wdata_i[CB_EN_SW:CB_EN_PIN];
        end
    end

    // Purpose: one-clock software store strobe, gated by its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_stb_q <= 1'b0;
        else        sw_stb_q <= wr_sw && bus_wdata_i[0] && en_q[NSRC-1];
    end

    assign ext_raw = {logic_evt_i, pin_evt_i};

    generate
        for (genvar g = 0; g < NUM_EXT; g++) begin : g_src
            evcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (ext_raw[g]),
                .rise_o  (ext_rise[g])
            );
        end
    endgenerate

    assign cap_any = |(ext_rise & en_q[NUM_EXT-1:0]) | sw_stb_q;

    evcap_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .clr_i     (clr_stb),
        .cap_i     (cap_any),
        .frz_req_i (frz_req_q),
        .cnt_o     (cnt_q),
        .img_o     (img_q),
        .ack_o     (ack_q),
        .pend_o    (pend_q)
    );

    // Purpose: read-data multiplexer over the four registers.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            REG_CTRL: begin
                bus_rdata_o[CB_RUN]              = run_q;
                bus_rdata_o[CB_FREEZE]           = frz_req_q;
                bus_rdata_o[CB_EN_SW:CB_EN_PIN]  = en_q;
                bus_rdata_o[CB_ACK]              = ack_q;
                bus_rdata_o[CB_PENDING]          = pend_q;
            end
            REG_IMAGE: bus_rdata_o = img_q;
            REG_COUNT: bus_rdata_o = cnt_q;
            default:   bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/evcap_timer_chk.sv
// Module evcap_timer_chk: temporal checks on the capture counter, bound
// into every evcap_timer instance. Assumes synchronous active-low reset.
module evcap_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic             clr_stb,
    input logic             frz_req_q,
    input logic             ack_q,
    input logic             pend_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] img_q
);
    assert_clear_zeroes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (cnt_q == '0) && (img_q == '0) && !pend_q);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !clr_stb) |=> cnt_q == $past(cnt_q) + 1'b1);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !clr_stb) |=> $stable(cnt_q));

    assert_ack_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ack_q == $past(frz_req_q));

    assert_image_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !clr_stb) |=> $stable(img_q));

    assert_pending_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_q && !clr_stb) |=> !pend_q);
endmodule

bind evcap_timer evcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .clr_stb   (clr_stb),
    .frz_req_q (frz_req_q),
    .ack_q     (ack_q),
    .pend_q    (pend_q),
    .cnt_q     (cnt_q),
    .img_q     (img_q)
);

// File: tb/evcap_timer_tb_top.sv
`timescale 1ns/1ps
// Bench evcap_timer_tb_top: directed tests for the capture counter. A second
// unit sees the inverted pin so the pair can measure a pulse width.
module evcap_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic        lev = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_a, rd_b;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    evcap_timer dut_i (
        .clk(clk), .rst_n(rst_n), .pin_evt_i(pin), .logic_evt_i(lev),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_a));

    evcap_timer dut_b (
        .clk(clk), .rst_n(rst_n), .pin_evt_i(~pin), .logic_evt_i(1'b0),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_b));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick(1);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] va, output logic [15:0] vb);
        addr = a;
        #1;
        va = rd_a;
        vb = rd_b;
    endtask

    logic [15:0] va, vb, c, im;

    // R2: reset state and no counting while run is 0
    task automatic t_reset;
        rd_reg(2'd0, va, vb); check("R2 ctrl reset", va, 16'h0000);
        rd_reg(2'd2, va, vb); check("R2 image reset", va, 16'h0000);
        tick(5);
        rd_reg(2'd3, va, vb); check("R2 count holds while stopped", va, 16'h0000);
    endtask

    // R1 and R2: clear plus run, then steady increment
    task automatic t_start;
        wr_reg(2'd0, 16'h003B);
        rd_reg(2'd3, va, vb); check("R1 count cleared", va, 16'h0000);
        rd_reg(2'd0, va, vb); check("R1 clear bit reads 0", va, 16'h0039);
        tick(1);
        rd_reg(2'd3, c, vb);
        tick(10);
        rd_reg(2'd3, va, vb); check("R2 ten increments", va, c + 16'd10);
    endtask

    // R3: software store
    task automatic t_sw;
        rd_reg(2'd3, c, vb);
        wr_reg(2'd1, 16'h0001);
        tick(1);
        rd_reg(2'd2, va, vb); check("R3 software snapshot", va, c + 16'd1);
    endtask

    // R4: pin store through synchroniser
    task automatic t_pin;
        rd_reg(2'd3, c, vb);
        pin = 1'b1; tick(1); pin = 1'b0;
        tick(2);
        rd_reg(2'd2, va, vb); check("R4 pin snapshot", va, c + 16'd2);
    endtask

    // R5 and R4: masked pin ignored, logic source captured
    task automatic t_mask;
        wr_reg(2'd0, 16'h0031);
        rd_reg(2'd2, im, vb);
        pin = 1'b1; tick(1); pin = 1'b0;
        tick(4);
        rd_reg(2'd2, va, vb); check("R5 masked pin ignored", va, im);
        rd_reg(2'd3, c, vb);
        lev = 1'b1; tick(1); lev = 1'b0;
        tick(2);
        rd_reg(2'd2, va, vb); check("R4 logic snapshot", va, c + 16'd2);
        wr_reg(2'd0, 16'h0039);
    endtask

    // R4: pulse width from a pair of units
    task automatic t_width(input int w);
        pin = 1'b1; tick(w); pin = 1'b0;
        tick(4);
        rd_reg(2'd2, va, vb);
        check("R4 pulse width", vb - va, 16'(w));
    endtask

    // R7: rising edges two clocks apart
    task automatic t_rapid;
        rd_reg(2'd3, c, vb);
        pin = 1'b1; tick(1); pin = 1'b0; tick(1); pin = 1'b1; tick(1); pin = 1'b0;
        tick(2);
        rd_reg(2'd2, va, vb); check("R7 second edge captured", va, c + 16'd4);
    endtask

    // R6 and R8: freeze, pending stores, release
    task automatic t_freeze;
        logic [15:0] c3;
        rd_reg(2'd2, im, vb);
        wr_reg(2'd0, 16'h003D);
        tick(1);
        rd_reg(2'd0, va, vb); check("R6 ack raised", va[6], 1'b1);
        wr_reg(2'd1, 16'h0001);
        tick(1);
        rd_reg(2'd2, va, vb); check("R6 image frozen", va, im);
        rd_reg(2'd0, va, vb); check("R8 pending set", va[7], 1'b1);
        rd_reg(2'd3, c, vb);
        tick(5);
        rd_reg(2'd3, va, vb); check("R6 counter runs during freeze", va, c + 16'd5);
        rd_reg(2'd3, c3, vb);
        wr_reg(2'd1, 16'h0001);
        tick(1);
        wr_reg(2'd0, 16'h0039);
        rd_reg(2'd2, va, vb); check("R6 image held until ack drops", va, im);
        tick(2);
        rd_reg(2'd2, va, vb); check("R8 newest pending released", va, c3 + 16'd1);
        rd_reg(2'd0, va, vb); check("R8 pending cleared", va[7], 1'b0);
    endtask

    // R1 and R9: clear, then wrap
    task automatic t_wrap;
        wr_reg(2'd0, 16'h003B);
        rd_reg(2'd2, va, vb); check("R1 image cleared", va, 16'h0000);
        rd_reg(2'd3, va, vb); check("R1 count cleared again", va, 16'h0000);
        tick(65535);
        rd_reg(2'd3, va, vb); check("R9 count at max", va, 16'hFFFF);
        tick(1);
        rd_reg(2'd3, va, vb); check("R9 wrap to zero", va, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_start();
        t_sw();
        t_pin();
        t_mask();
        t_width(7);
        t_width(2);
        t_rapid();
        t_freeze();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule